// File: doc/BRIEF.md
# Paged EEPROM Write Controller

This block accepts a write stream of bytes and commits them to a 512-byte nonvolatile array. The array is modelled here as on-chip storage. A burst opens with a start pulse that carries an address inside a 256-byte block, together with a separate block-select bit. Data bytes then follow, and an end pulse closes the burst. The bytes collect in an eight-byte page buffer. The in-page offset advances by one per byte and folds back to the page's first byte when it passes the page's last byte, so a long burst overwrites its own earlier bytes and never spills into the next page.

When the burst closes, a programming cycle of a fixed number of clocks begins and `busy` goes high. At the end of that cycle, only the buffer bytes that the burst actually wrote are copied into the array. Any request presented during the cycle is refused: `nack` flags it and it has no effect. A serial bus front end can use `nack` to withhold its acknowledge. Reads are combinational from a pointer register. The pointer is loaded with a 9-bit address and then steps forward through the whole array, wrapping from the top to address 0.

Top module: `eepw_page_writer`

## Requirements
- R1: After reset, `busy` and `nack` are low and every array byte reads as `ERASE_VAL` (default 8'hFF).
- R2: A burst's page is taken from `wr_bank` as address bit 8 and `wr_addr[7:3]` as bits 7..3, both captured on the accepted `wr_start`. A change of `wr_bank` later in the burst has no effect.
- R3: Each `wr_valid` byte lands at the current offset, which starts at `wr_addr[2:0]` and then increments modulo 8 within the page. A later byte at the same offset replaces the earlier one.
- R4: At commit, only offsets written during the burst change in the array. The other bytes of the page keep their previous contents.
- R5: When `wr_end` closes a burst holding at least one byte, `busy` is high for exactly `PROG_CYCLES` cycles starting in the next cycle. The array shows the new bytes in the first cycle after `busy` falls, and `busy` is low in that cycle.
- R6: While `busy` is high, any of `wr_start`, `wr_valid`, `wr_end`, `rd_start` or `rd_next` raises `nack` in the same cycle. The request changes neither the array nor the read pointer.
- R7: A burst closed with no data byte starts no programming cycle, so `busy` stays low.
- R8: `rd_start` loads `rd_addr` into the read pointer, and `rd_next` advances it by one modulo 512, crossing page and block edges. `rd_data` shows the addressed byte from the cycle after either request.
- R9: `rd_data` does not change during a programming cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Opens a burst at `wr_bank`/`wr_addr` |
| wr_bank | input | 1 | 256-byte block select, captured with `wr_start` |
| wr_addr | input | 8 | Start address inside the block |
| wr_valid | input | 1 | Data byte present on `wr_data` |
| wr_data | input | 8 | Data byte |
| wr_end | input | 1 | Closes the burst and starts programming |
| rd_start | input | 1 | Load read pointer from `rd_addr` |
| rd_next | input | 1 | Advance read pointer by one |
| rd_addr | input | 9 | Full array read address |
| rd_data | output | 8 | Byte at the read pointer |
| busy | output | 1 | Programming cycle in progress |
| nack | output | 1 | Request refused because `busy` is high |

## Verification
Several properties are checked on every cycle. The length of each busy window is checked against `PROG_CYCLES` by a counter in the checker. Busy may only rise right after an end pulse, it may not rise in the cycle after it falls, and `rd_data` must stay frozen inside a busy window. The remaining behaviour can only be shown by the bench's scenarios, which compare streamed reads against a reference array model. These scenarios cover the page-wrap overwrite order, the merge of partially written pages, the block-select bit changing in mid-burst, the empty burst, and requests refused during programming that must leave both the array and the read pointer untouched.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eepw_state_t;
endpackage

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               open_i,
  input  logic [OFF_W-1:0]                   off_i,
  input  logic                               push_i,
  input  logic [DATA_W-1:0]                  din_i,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]  lanes_o,
  output logic [PAGE_BYTES-1:0]              mask_o
);
  logic [OFF_W-1:0]      off_q, off_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;

  // offset wraps inside the page because it is only OFF_W bits wide
  always_comb begin
    off_d  = off_q;
    mask_d = mask_q;
    if (open_i) begin
      off_d  = off_i;
      mask_d = '0;
    end else if (push_i) begin
      off_d  = off_q + OFF_W'(1);
      mask_d = mask_q | (PAGE_BYTES'(1) << off_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      mask_q <= '0;
    end else begin
      off_q  <= off_d;
      mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic lane_en;
    assign lane_en = push_i && (off_q == OFF_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lanes_o[g] <= '0;
      else if (lane_en) lanes_o[g] <= din_i;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/eepw_prog_timer.sv
module eepw_prog_timer #(
  parameter int PROG_CYCLES = 20,
  parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = CNT_W'(PROG_CYCLES - 1);
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/eepw_nv_array.sv
module eepw_nv_array #(
  parameter int          DATA_W      = 8,
  parameter int          DEPTH_BYTES = 512,
  parameter int          PAGE_BYTES  = 8,
  parameter logic [7:0]  ERASE_VAL   = 8'hFF,
  parameter int          ADDR_W      = $clog2(DEPTH_BYTES),
  parameter int          OFF_W       = $clog2(PAGE_BYTES),
  parameter int          PG_W        = ADDR_W - OFF_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit_i,
  input  logic [PG_W-1:0]                   page_i,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] lanes_i,
  input  logic [PAGE_BYTES-1:0]             mask_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [DATA_W-1:0]                 rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH_BYTES; a++) mem_q[a] <= DATA_W'(ERASE_VAL);
    end else if (commit_i) begin
      for (int l = 0; l < PAGE_BYTES; l++) begin
        if (mask_i[l]) mem_q[{page_i, OFF_W'(l)}] <= lanes_i[l];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eepw_page_writer.sv
module eepw_page_writer #(
  parameter int         DATA_W      = 8,
  parameter int         DEPTH_BYTES = 512,
  parameter int         BLOCK_BYTES = 256,
  parameter int         PAGE_BYTES  = 8,
  parameter int         PROG_CYCLES = 20,
  parameter logic [7:0] ERASE_VAL   = 8'hFF,
  localparam int        ADDR_W      = $clog2(DEPTH_BYTES),
  localparam int        BLK_AW      = $clog2(BLOCK_BYTES),
  localparam int        BANK_W      = ADDR_W - BLK_AW,
  localparam int        OFF_W       = $clog2(PAGE_BYTES),
  localparam int        PG_W        = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [BLK_AW-1:0] wr_addr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_end,
  input  logic              rd_start,
  input  logic              rd_next,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              nack
);
  import eepw_pkg::*;

  eepw_state_t       state_q, state_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic [ADDR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic              buf_open, buf_push, tmr_load, tmr_last, do_commit;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_lanes;
  logic [PAGE_BYTES-1:0]             buf_mask;

  always_comb begin
    state_d   = state_q;
    page_d    = page_q;
    rd_ptr_d  = rd_ptr_q;
    buf_open  = 1'b0;
    buf_push  = 1'b0;
    tmr_load  = 1'b0;
    do_commit = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_start) begin
          buf_open = 1'b1;
          page_d   = {wr_bank, wr_addr[BLK_AW-1:OFF_W]};
          state_d  = ST_LOAD;
        end
      end
      ST_LOAD: begin
        buf_push = wr_valid;
        if (wr_end) begin
          if ((|buf_mask) || wr_valid) begin
            tmr_load = 1'b1;
            state_d  = ST_PROG;
          end else begin
            state_d  = ST_IDLE;
          end
        end
      end
      ST_PROG: begin
        if (tmr_last) begin
          do_commit = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_q != ST_PROG) begin
      if (rd_start)     rd_ptr_d = rd_addr;
      else if (rd_next) rd_ptr_d = rd_ptr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      rd_ptr_q <= '0;
    end else begin
      state_q  <= state_d;
      page_q   <= page_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  eepw_page_buf #(
    .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .open_i(buf_open), .off_i(wr_addr[OFF_W-1:0]),
    .push_i(buf_push), .din_i(wr_data), .lanes_o(buf_lanes), .mask_o(buf_mask)
  );

  eepw_prog_timer #(
    .PROG_CYCLES(PROG_CYCLES)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .last_o(tmr_last)
  );

  eepw_nv_array #(
    .DATA_W(DATA_W), .DEPTH_BYTES(DEPTH_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .ERASE_VAL(ERASE_VAL)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .commit_i(do_commit), .page_i(page_q),
    .lanes_i(buf_lanes), .mask_i(buf_mask), .rd_addr_i(rd_ptr_q),
    .rd_data_o(rd_data)
  );

  assign busy = (state_q == ST_PROG);
  assign nack = busy & (wr_start | wr_valid | wr_end | rd_start | rd_next);
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
  parameter int PROG_CYCLES = 20,
  parameter int DATA_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wr_end,
  input logic [DATA_W-1:0] rd_data
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else           run_q <= '0;
  end

  // R5: busy window is exactly PROG_CYCLES long
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 32'(PROG_CYCLES)));

  // R5: programming only starts right after a burst is closed
  p_busy_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_end));

  // R5: at least one idle cycle follows each programming cycle
  p_busy_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !busy);

  // R9: read data frozen while programming
  p_rd_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(rd_data)));
endmodule

bind eepw_page_writer eepw_checker #(
  .PROG_CYCLES(PROG_CYCLES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_end(wr_end), .rd_data(rd_data)
);

// File: tb/test_eepw_page_writer.sv
module test_eepw_page_writer;
  localparam int PROG = 12;

  logic       clk, rst_n;
  logic       wr_start, wr_bank, wr_valid, wr_end, rd_start, rd_next;
  logic [7:0] wr_addr, wr_data, rd_data;
  logic [8:0] rd_addr;
  logic       busy, nack;

  int total, bad;
  logic [7:0] model [512];

  typedef struct { int addr; logic [7:0] data; } exp_t;
  exp_t exp_q[$];
  logic arm;

  eepw_page_writer #(.PROG_CYCLES(PROG)) i_eepw_page_writer (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_valid(wr_valid), .wr_data(wr_data), .wr_end(wr_end),
    .rd_start(rd_start), .rd_next(rd_next), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .nack(nack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // monitor: compare read results one cycle after an accepted request
  always @(posedge clk) arm <= rst_n && (rd_start || rd_next) && !busy;
  always @(negedge clk) begin
    if (arm && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check($sformatf("R8 read at %0h", e.addr), int'(rd_data), int'(e.data));
    end
  end

  task automatic rd_seq(input int a, input int n);
    @(negedge clk);
    rd_start = 1'b1; rd_addr = 9'(a);
    exp_q.push_back('{a, model[a]});
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      rd_start = 1'b0; rd_next = 1'b1;
      exp_q.push_back('{(a + k) % 512, model[(a + k) % 512]});
    end
    @(negedge clk);
    rd_start = 1'b0; rd_next = 1'b0;
  endtask

  task automatic burst(input bit bank, input logic [7:0] addr, input int n,
                       input logic [7:0] seed, input bit end_last,
                       input bit flip, input bit poke);
    logic [7:0] pbuf [8];
    bit         pm   [8];
    logic [2:0] off;
    int         cnt;
    logic [7:0] held;
    for (int i = 0; i < 8; i++) pm[i] = 1'b0;
    off = addr[2:0];
    @(negedge clk);
    wr_start = 1'b1; wr_bank = bank; wr_addr = addr;
    @(negedge clk);
    wr_start = 1'b0;
    if (flip) wr_bank = ~bank;
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1; wr_data = seed + 8'(i);
      pbuf[off] = seed + 8'(i); pm[off] = 1'b1; off = off + 3'd1;
      if (i == n - 1 && end_last) wr_end = 1'b1;
      @(negedge clk);
    end
    wr_valid = 1'b0; wr_end = 1'b0;
    if (!(end_last && n > 0)) begin
      wr_end = 1'b1;
      @(negedge clk);
      wr_end = 1'b0;
    end
    cnt = 0;
    held = rd_data;
    while (busy && cnt < 10 * PROG) begin
      check("R9 rd_data frozen", int'(rd_data), int'(held));
      if (cnt == 0 && poke) begin
        wr_start = 1'b1; wr_bank = 1'b0; wr_addr = 8'hF0;
        wr_valid = 1'b1; wr_data = 8'h55; rd_next = 1'b1;
        #1 check("R6 nack while busy", int'(nack), 1);
      end
      cnt++;
      @(negedge clk);
      wr_start = 1'b0; wr_valid = 1'b0; rd_next = 1'b0;
    end
    if (n > 0) check("R5 busy length", cnt, PROG);
    else       check("R7 empty burst no busy", cnt, 0);
    for (int i = 0; i < 8; i++)
      if (pm[i]) model[{bank, addr[7:3], 3'(i)}] = pbuf[i];
    @(negedge clk);
    check("R5 busy low after fall", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; wr_start = 0; wr_bank = 0; wr_addr = 0; wr_valid = 0;
    wr_data = 0; wr_end = 0; rd_start = 0; rd_next = 0; rd_addr = 0;
    for (int a = 0; a < 512; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 nack after reset", int'(nack), 0);
    check("R1 erased byte 0", int'(rd_data), 8'hFF);
    rd_seq(9'h1FE, 4);                       // R1 erased, R8 wrap 511 -> 0

    burst(1'b0, 8'h10, 3, 8'h20, 1'b1, 1'b0, 1'b0);  // R4/R5, end with last byte
    rd_seq(9'h00E, 8);                       // R4 neighbours keep FF, R8 crosses page

    burst(1'b1, 8'h0D, 5, 8'hA0, 1'b0, 1'b0, 1'b0);  // R3 wrap 5,6,7,0,1
    rd_seq(9'h108, 8);
    burst(1'b1, 8'h08, 10, 8'hB0, 1'b0, 1'b0, 1'b0); // R3 overwrite after wrap
    rd_seq(9'h108, 8);

    burst(1'b0, 8'h31, 2, 8'hC0, 1'b0, 1'b1, 1'b0);  // R2 bank captured at start
    rd_seq(9'h030, 4);
    rd_seq(9'h130, 4);

    burst(1'b0, 8'h50, 0, 8'h00, 1'b0, 1'b0, 1'b0);  // R7 empty burst

    rd_seq(9'h0A0, 1);                       // R6 pointer parked at 0A0
    burst(1'b1, 8'hE3, 4, 8'hD0, 1'b0, 1'b0, 1'b1);  // R6 poke during busy
    check("R6 pointer not advanced", int'(rd_data), int'(model[9'h0A0]));
    rd_seq(9'h0F0, 1);                       // R6 refused write had no effect
    rd_seq(9'h1E0, 8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule